// File: doc/BRIEF.md
# Two-Wire Controller Indirect Register Bridge

This block sits between a host bus and the small 8-bit register set of a two-wire serial bus controller. The host never addresses those registers directly. It writes a single 64-bit command word that carries an opcode, a direction flag, a 3-bit register index and a data value, with the top bit set to mark the word as pending. The bridge holds the word, performs the internal register access a fixed number of clocks later, and then clears the pending bit. On a read, the selected register value is placed in the low bits of the data field of that same word.

The host learns that an access has finished by reading the command word back and watching the pending bit. While that bit is set, further host writes are dropped, so an access in flight cannot be altered. Only the register-access opcode reaches the register set. One index reaches two registers: a write to it loads the clock control register, and a read from it returns the live status value that the bus engine supplies. Another index performs a soft reset of the writable registers.

Top module: `twowire_cmd_bridge`

## Requirements
- R1: While reset is asserted, the command word reads back as all zeros, the four register outputs hold their reset values (zero by default) and the soft reset pulse is low.
- R2: When no access is pending, a host write is stored and read back unchanged from the next cycle; if bit 63 of the written word is 1, bit 63 reads 1 (access pending).
- R3: The pending bit stays set for exactly LATENCY clocks (default 2) after the accepting clock edge. It reads 1 in the first LATENCY-1 cycles after that edge and 0 from the LATENCY-th edge onward.
- R4: A host write that arrives while bit 63 of the stored word is 1 is ignored: the access completes with the fields of the word that started it.
- R5: An access with opcode 6 (bits 60:57) and direction flag 0 (bit 56, write) loads data bits 7:0 into the selected register: index (bits 34:32) 1 selects the data register, 2 the control register and 4 the extended slave address. The new value appears on that register's output once the pending bit has cleared.
- R6: Index 3 is shared. An opcode 6 write (bit 56 = 0) loads the clock control register. An opcode 6 read (bit 56 = 1) returns the engine status input and leaves clock control unchanged.
- R7: An opcode 6 read (bit 56 = 1) replaces data bits 31:0 with the selected register value, zero-extended. Bits 62:32 of the word are unchanged.
- R8: An opcode 6 write to index 7 returns the data, control, clock control and extended address registers to their reset values. The soft reset output is high for exactly one cycle, the cycle after completion.
- R9: An access with any opcode other than 6 changes no register and leaves the data field unchanged. An opcode 6 access to index 0, 5 or 6 changes no register, and a read from one of those indices returns zero.
- R10: A host write with bit 63 = 0 is stored but starts no access: no register changes and the word stays as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Command word as currently held (poll bit 63) |
| eng_status_i | input | REG_W | Status value supplied by the bus engine |
| data_reg_o | output | REG_W | Data register contents |
| ctl_reg_o | output | REG_W | Control register contents |
| clk_ctl_o | output | REG_W | Clock control register contents |
| ext_addr_o | output | REG_W | Extended slave address register contents |
| soft_rst_o | output | 1 | One-cycle pulse after a soft reset access |

## Verification
The hardest case to reach from the ports is a second host write that lands inside the short busy window, so that it has to be dropped. The stimulus produces it on purpose by driving a different pending word in the cycle just after an access is accepted. It then checks that the access completes with the first word's index and data. The shared index 3 is also hard to observe, because its write-side register can never be read back through that index. The bench therefore writes clock control, reads index 3 against a different status value, and checks the clock control output at the port. Random accesses with a fixed seed mix every index, both directions and foreign opcodes against a reference model kept in the bench.

// File: rtl/twb_pkg.sv
package twb_pkg;

   localparam int unsigned WORD_W = 64;
   localparam int unsigned DATA_FIELD_W = 32;
   localparam int unsigned IDX_W = 3;
   localparam int unsigned NUM_IDX = 1 << IDX_W;

   localparam logic [3:0] OP_REG_ACCESS = 4'd6;

   localparam logic [IDX_W-1:0] IDX_DATA     = 3'd1;
   localparam logic [IDX_W-1:0] IDX_CTL      = 3'd2;
   localparam logic [IDX_W-1:0] IDX_CLK_STAT = 3'd3;
   localparam logic [IDX_W-1:0] IDX_EXT_ADDR = 3'd4;
   localparam logic [IDX_W-1:0] IDX_SOFT_RST = 3'd7;

   // Command word, most significant field first (bit 63 down to bit 0).
   typedef struct packed {
      logic        pending;
      logic        slave_only;
      logic        ext_index;
      logic [3:0]  opcode;
      logic        rd_flag;
      logic        size_ovr;
      logic [2:0]  size;
      logic [1:0]  rsvd;
      logic [9:0]  dev_addr;
      logic [4:0]  aux_addr;
      logic [2:0]  reg_idx;
      logic [31:0] data;
   } cmd_word_t;

endpackage

// File: rtl/twb_cmd_decode.sv
module twb_cmd_decode
   import twb_pkg::*;
(
   input  cmd_word_t        word_i,
   output logic             reg_access_o,
   output logic             rd_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [7:0]       idx_onehot_o
);

   always_comb begin
      reg_access_o = (word_i.opcode == OP_REG_ACCESS);
      rd_o         = word_i.rd_flag;
      idx_o        = word_i.reg_idx;
   end

   for (genvar g = 0; g < NUM_IDX; g++) begin : g_sel
      assign idx_onehot_o[g] = (word_i.reg_idx == IDX_W'(g));
   end

endmodule

// File: rtl/twb_latency_timer.sv
module twb_latency_timer #(
   parameter int unsigned LATENCY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic done_o
);

   localparam int unsigned CNT_W = $clog2(LATENCY + 1);

   if (LATENCY < 1) begin : g_bad_latency
      $error("twb_latency_timer: LATENCY must be at least 1");
   end

   if (LATENCY == 1) begin : g_single
      logic flag_q;
      always_ff @(posedge clk) begin
         if (!rst_n) flag_q <= 1'b0;
         else        flag_q <= start_i;
      end
      assign done_o = flag_q;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)              cnt_q <= '0;
         else if (start_i)        cnt_q <= CNT_W'(LATENCY);
         else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
      assign done_o = (cnt_q == CNT_W'(1));
   end

endmodule

// File: rtl/twb_regfile.sv
module twb_regfile
   import twb_pkg::*;
#(
   parameter int unsigned REG_W    = 8,
   parameter logic [REG_W-1:0] DATA_RST = '0,
   parameter logic [REG_W-1:0] CTL_RST  = '0,
   parameter logic [REG_W-1:0] CLK_RST  = '0,
   parameter logic [REG_W-1:0] EXT_RST  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb_i,
   input  logic [7:0]       wr_sel_i,
   input  logic [REG_W-1:0] wr_val_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   input  logic [REG_W-1:0] status_i,
   output logic [REG_W-1:0] rd_val_o,
   output logic [REG_W-1:0] data_o,
   output logic [REG_W-1:0] ctl_o,
   output logic [REG_W-1:0] clk_o,
   output logic [REG_W-1:0] ext_o,
   output logic             soft_rst_o
);

   function automatic logic [REG_W-1:0] rst_of(int unsigned i);
      case (i)
         32'(IDX_DATA):     return DATA_RST;
         32'(IDX_CTL):      return CTL_RST;
         32'(IDX_CLK_STAT): return CLK_RST;
         32'(IDX_EXT_ADDR): return EXT_RST;
         default:           return '0;
      endcase
   endfunction

   function automatic logic is_storage(int unsigned i);
      return (i == 32'(IDX_DATA)) || (i == 32'(IDX_CTL)) ||
             (i == 32'(IDX_CLK_STAT)) || (i == 32'(IDX_EXT_ADDR));
   endfunction

   logic [REG_W-1:0] store_q [NUM_IDX];
   logic             srst;

   assign srst = wr_stb_i && wr_sel_i[IDX_SOFT_RST];

   always_ff @(posedge clk) begin
      for (int unsigned i = 0; i < NUM_IDX; i++) begin
         if (!rst_n || srst)                       store_q[i] <= rst_of(i);
         else if (wr_stb_i && wr_sel_i[i] && is_storage(i)) store_q[i] <= wr_val_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) soft_rst_o <= 1'b0;
      else        soft_rst_o <= srst;
   end

   // Reads of the shared index see the engine status, never clock control.
   always_comb begin
      if (rd_idx_i == IDX_CLK_STAT)             rd_val_o = status_i;
      else if (is_storage(32'(rd_idx_i)))       rd_val_o = store_q[rd_idx_i];
      else                                      rd_val_o = '0;
   end

   assign data_o = store_q[IDX_DATA];
   assign ctl_o  = store_q[IDX_CTL];
   assign clk_o  = store_q[IDX_CLK_STAT];
   assign ext_o  = store_q[IDX_EXT_ADDR];

endmodule

// File: rtl/twowire_cmd_bridge.sv
module twowire_cmd_bridge
   import twb_pkg::*;
#(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned LATENCY  = 2,
   parameter logic [REG_W-1:0] DATA_RST = '0,
   parameter logic [REG_W-1:0] CTL_RST  = '0,
   parameter logic [REG_W-1:0] CLK_RST  = '0,
   parameter logic [REG_W-1:0] EXT_RST  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr_en,
   input  logic [63:0]      host_wdata,
   output logic [63:0]      host_rdata,
   input  logic [REG_W-1:0] eng_status_i,
   output logic [REG_W-1:0] data_reg_o,
   output logic [REG_W-1:0] ctl_reg_o,
   output logic [REG_W-1:0] clk_ctl_o,
   output logic [REG_W-1:0] ext_addr_o,
   output logic             soft_rst_o
);

   if (REG_W < 1 || REG_W > DATA_FIELD_W) begin : g_bad_width
      $error("twowire_cmd_bridge: REG_W must be within 1..32");
   end

   cmd_word_t        word_q;
   cmd_word_t        wdata_s;
   logic             accept;
   logic             done;
   logic             reg_access;
   logic             rd;
   logic [IDX_W-1:0] idx;
   logic [7:0]       idx_onehot;
   logic [REG_W-1:0] rd_val;
   logic             wr_stb;

   assign wdata_s = cmd_word_t'(host_wdata);
   assign accept  = host_wr_en && !word_q.pending;

   twb_cmd_decode u_decode (
      .word_i       (word_q),
      .reg_access_o (reg_access),
      .rd_o         (rd),
      .idx_o        (idx),
      .idx_onehot_o (idx_onehot)
   );

   twb_latency_timer #(.LATENCY(LATENCY)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (accept && wdata_s.pending),
      .done_o  (done)
   );

   assign wr_stb = done && reg_access && !rd;

   twb_regfile #(
      .REG_W    (REG_W),
      .DATA_RST (DATA_RST),
      .CTL_RST  (CTL_RST),
      .CLK_RST  (CLK_RST),
      .EXT_RST  (EXT_RST)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_stb_i   (wr_stb),
      .wr_sel_i   (idx_onehot),
      .wr_val_i   (word_q.data[REG_W-1:0]),
      .rd_idx_i   (idx),
      .status_i   (eng_status_i),
      .rd_val_o   (rd_val),
      .data_o     (data_reg_o),
      .ctl_o      (ctl_reg_o),
      .clk_o      (clk_ctl_o),
      .ext_o      (ext_addr_o),
      .soft_rst_o (soft_rst_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (accept) begin
         word_q <= wdata_s;
      end else if (done) begin
         word_q.pending <= 1'b0;
         if (reg_access && rd) word_q.data <= DATA_FIELD_W'(rd_val);
      end
   end

   assign host_rdata = word_q;

endmodule

// File: rtl/twowire_cmd_bridge_chk.sv
module twowire_cmd_bridge_chk #(
   parameter int unsigned REG_W   = 8,
   parameter int unsigned LATENCY = 2,
   parameter logic [REG_W-1:0] DATA_RST = '0,
   parameter logic [REG_W-1:0] CTL_RST  = '0,
   parameter logic [REG_W-1:0] CLK_RST  = '0,
   parameter logic [REG_W-1:0] EXT_RST  = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_wr_en,
   input logic [63:0]      host_rdata,
   input logic [REG_W-1:0] data_reg_o,
   input logic [REG_W-1:0] ctl_reg_o,
   input logic [REG_W-1:0] clk_ctl_o,
   input logic [REG_W-1:0] ext_addr_o,
   input logic             soft_rst_o
);

   localparam int unsigned AGE_W = $clog2(LATENCY + 1) + 1;
   logic [AGE_W-1:0] age_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             age_q <= '0;
      else if (host_rdata[63]) age_q <= age_q + 1'b1;
      else                    age_q <= '0;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (host_rdata == 64'd0 && !soft_rst_o));

   // R3
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rdata[63] && age_q < AGE_W'(LATENCY - 1)) |=> host_rdata[63]);

   // R3
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rdata[63] && age_q == AGE_W'(LATENCY - 1)) |=> !host_rdata[63]);

   // R4
   fields_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdata[63] |=> $stable(host_rdata[62:32]));

   // R10
   idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_rdata[63] && !host_wr_en) |=> (!host_rdata[63] && $stable(host_rdata)));

   // R8
   soft_rst_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |-> (data_reg_o == DATA_RST && ctl_reg_o == CTL_RST &&
                      clk_ctl_o == CLK_RST && ext_addr_o == EXT_RST));

   // R8
   soft_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |=> !soft_rst_o);

endmodule

bind twowire_cmd_bridge twowire_cmd_bridge_chk #(
   .REG_W    (REG_W),
   .LATENCY  (LATENCY),
   .DATA_RST (DATA_RST),
   .CTL_RST  (CTL_RST),
   .CLK_RST  (CLK_RST),
   .EXT_RST  (EXT_RST)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr_en (host_wr_en),
   .host_rdata (host_rdata),
   .data_reg_o (data_reg_o),
   .ctl_reg_o  (ctl_reg_o),
   .clk_ctl_o  (clk_ctl_o),
   .ext_addr_o (ext_addr_o),
   .soft_rst_o (soft_rst_o)
);

// File: tb/twowire_cmd_bridge_bench.sv
module twowire_cmd_bridge_bench;

   localparam int CLK_PERIOD = 10;
   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_en = 1'b0;
   logic [63:0] host_wdata = '0;
   logic [63:0] host_rdata;
   logic [7:0]  eng_status_i = '0;
   logic [7:0]  data_reg_o, ctl_reg_o, clk_ctl_o, ext_addr_o;
   logic        soft_rst_o;

   int tests = 0;
   int fails = 0;

   logic [7:0] m_data = 0, m_ctl = 0, m_clk = 0, m_ext = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   twowire_cmd_bridge #(.REG_W(8), .LATENCY(LAT)) u_twowire_cmd_bridge (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_wr_en   (host_wr_en),
      .host_wdata   (host_wdata),
      .host_rdata   (host_rdata),
      .eng_status_i (eng_status_i),
      .data_reg_o   (data_reg_o),
      .ctl_reg_o    (ctl_reg_o),
      .clk_ctl_o    (clk_ctl_o),
      .ext_addr_o   (ext_addr_o),
      .soft_rst_o   (soft_rst_o)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(logic v, logic [3:0] op, logic r,
                                      logic [2:0] idx, logic [31:0] d,
                                      logic [26:0] other);
      logic [63:0] w;
      w = '0;
      w[63] = v; w[60:57] = op; w[56] = r; w[34:32] = idx; w[31:0] = d;
      w[62:61] = other[1:0]; w[55:35] = other[22:2];
      return w;
   endfunction

   function automatic logic [7:0] model_read(logic [2:0] idx, logic [7:0] st);
      case (idx)
         3'd1: return m_data;
         3'd2: return m_ctl;
         3'd3: return st;
         3'd4: return m_ext;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [63:0] exp_word(logic [63:0] w, logic [7:0] st);
      logic [63:0] e;
      e = w;
      e[63] = 1'b0;
      if (w[60:57] == 4'd6 && w[56]) e[31:0] = {24'd0, model_read(w[34:32], st)};
      return e;
   endfunction

   task automatic model_apply(logic [63:0] w);
      if (w[60:57] == 4'd6 && !w[56]) begin
         case (w[34:32])
            3'd1: m_data = w[7:0];
            3'd2: m_ctl  = w[7:0];
            3'd3: m_clk  = w[7:0];
            3'd4: m_ext  = w[7:0];
            3'd7: begin m_data = 0; m_ctl = 0; m_clk = 0; m_ext = 0; end
            default: ;
         endcase
      end
   endtask

   task automatic chk_regs(string tag);
      chk({tag, " data"}, {56'd0, data_reg_o}, {56'd0, m_data});
      chk({tag, " ctl"},  {56'd0, ctl_reg_o},  {56'd0, m_ctl});
      chk({tag, " clk"},  {56'd0, clk_ctl_o},  {56'd0, m_clk});
      chk({tag, " ext"},  {56'd0, ext_addr_o}, {56'd0, m_ext});
   endtask

   // Full access with valid bit set; optional intruding write one cycle in.
   task automatic access(logic [63:0] w, logic [7:0] st, bit intrude,
                         logic [63:0] other_w, string tag);
      logic [63:0] e;
      eng_status_i = st;
      @(negedge clk);
      host_wdata = w; host_wr_en = 1'b1;
      @(negedge clk);
      host_wr_en = 1'b0;
      chk({tag, " R2 pending after accept"}, {63'd0, host_rdata[63]}, 64'd1);
      if (intrude) begin host_wdata = other_w; host_wr_en = 1'b1; end
      @(negedge clk);
      host_wr_en = 1'b0;
      chk({tag, " R3 still pending"}, {63'd0, host_rdata[63]}, 64'd1);
      e = exp_word(w, st);
      model_apply(w);
      @(negedge clk);
      chk({tag, " R3 R7 completed word"}, host_rdata, e);
      chk({tag, " R8 pulse"}, {63'd0, soft_rst_o},
          {63'd0, (w[60:57] == 4'd6 && !w[56] && w[34:32] == 3'd7)});
      chk_regs({tag, " R5 R6 R9 regs"});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_2024));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 word in reset", host_rdata, 64'd0);
      chk("R1 pulse in reset", {63'd0, soft_rst_o}, 64'd0);
      chk_regs("R1");
      rst_n = 1'b1;
      @(negedge clk);

      // R5 directed writes
      access(mk(1, 4'd6, 0, 3'd1, 32'hDEAD_BEA5, 27'h0), 8'h11, 0, 0, "R5 data");
      access(mk(1, 4'd6, 0, 3'd2, 32'h0000_00C4, 27'h155), 8'h11, 0, 0, "R5 ctl");
      access(mk(1, 4'd6, 0, 3'd4, 32'h0000_007E, 27'h3), 8'h11, 0, 0, "R5 ext");
      // R6 shared index
      access(mk(1, 4'd6, 0, 3'd3, 32'h0000_0033, 27'h0), 8'hF8, 0, 0, "R6 clk write");
      access(mk(1, 4'd6, 1, 3'd3, 32'hFFFF_FFFF, 27'h7FF), 8'hF8, 0, 0, "R6 status read");
      chk("R6 clk untouched by read", {56'd0, clk_ctl_o}, 64'h33);
      // R7 reads
      access(mk(1, 4'd6, 1, 3'd2, 32'h1234_5678, 27'h2AA), 8'h00, 0, 0, "R7 ctl read");
      access(mk(1, 4'd6, 1, 3'd1, 32'hAAAA_AAAA, 27'h0), 8'h00, 0, 0, "R7 data read");
      // R9 foreign opcode and unmapped index
      access(mk(1, 4'd5, 0, 3'd2, 32'h0000_0099, 27'h0), 8'h00, 0, 0, "R9 foreign op");
      access(mk(1, 4'd6, 1, 3'd5, 32'hCAFE_0000, 27'h0), 8'h00, 0, 0, "R9 unmapped read");
      access(mk(1, 4'd6, 0, 3'd6, 32'h0000_0055, 27'h0), 8'h00, 0, 0, "R9 unmapped write");
      // R4 intruding write dropped
      access(mk(1, 4'd6, 0, 3'd2, 32'h0000_0021, 27'h0), 8'h00, 1,
             mk(1, 4'd6, 0, 3'd4, 32'h0000_00EE, 27'h1), "R4 intrude");
      chk("R4 ext kept", {56'd0, ext_addr_o}, 64'h7E);
      // R8 soft reset
      access(mk(1, 4'd6, 0, 3'd7, 32'h0000_00FF, 27'h0), 8'h00, 0, 0, "R8 soft reset");
      @(negedge clk);
      chk("R8 pulse one cycle", {63'd0, soft_rst_o}, 64'd0);

      // R10 word without valid bit
      access(mk(1, 4'd6, 0, 3'd2, 32'h0000_0042, 27'h0), 8'h00, 0, 0, "R10 setup");
      @(negedge clk);
      host_wdata = mk(0, 4'd6, 0, 3'd2, 32'h0000_0017, 27'h9); host_wr_en = 1'b1;
      @(negedge clk);
      host_wr_en = 1'b0;
      chk("R10 stored", host_rdata, mk(0, 4'd6, 0, 3'd2, 32'h0000_0017, 27'h9));
      repeat (LAT + 2) @(negedge clk);
      chk("R10 word kept", host_rdata, mk(0, 4'd6, 0, 3'd2, 32'h0000_0017, 27'h9));
      chk("R10 ctl kept", {56'd0, ctl_reg_o}, 64'h42);

      // Random mix
      for (int i = 0; i < 300; i++) begin
         logic [3:0] op;
         op = ($urandom_range(0, 3) != 0) ? 4'd6 : 4'($urandom_range(0, 15));
         access(mk(1, op, 1'($urandom), 3'($urandom), $urandom, 27'($urandom)),
                8'($urandom), ($urandom_range(0, 7) == 0),
                mk(1, 4'd6, 0, 3'($urandom), $urandom, 27'($urandom)), "rand");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule